// File: doc/BRIEF.md
# Multichannel ADC Scan Register Controller

This block is the register front end of a 32-channel analog input path. Software reaches it over a byte-wide bus with sixteen locations. It holds the first and last channel of a scan, an analog configuration byte, a code for the pause between channels, and the enables for the sample buffer and for scanning. A write to location 0 starts either one conversion or a full scan. While that work runs, the block shows a busy flag and the channel being converted. Each 16-bit result is read back as two bytes.

Every conversion result is held in a last-sample register. When the buffer is enabled, the result is also pushed into a sample FIFO, and reading the high byte pops that FIFO. When a sequence ends, the block can raise an interrupt, which software clears through the control location. The converter itself is a stub. After a set number of cycles it returns the byte `STUB_HI` followed by three zero bits and the channel number. After reset, the readback values are fixed, so a driver can probe them to detect the block.

Top module: `adc_scan_ctl`

## Requirements
- R1: After reset, location 8 reads 0x60, location 7 reads 0x80, and location 9 reads 0x00, and `irq` is low. If software then writes 0x80 to location 2, 0xFF to location 3 and 0x0C to location 0xB, those three locations read back 0x00, 0x1F and 0x0C, and locations 7, 8 and 9 still read 0x80, 0x60 and 0x00.
- R2: Locations 2 (first channel) and 3 (last channel) keep only the low 5 bits of each write. Bits 7:5 read as zero.
- R3: Location 0xB stores bits 5:0 of each write: bits 5:4 are the pause code, bit 3 is range, bit 2 is unipolar, and bits 1:0 are gain. Bit 6 reads 0 and bit 7 reads the busy flag.
- R4: Location 9 stores bit 7 (interrupt enable), bit 1 (hardware clock select) and bit 0 (timer select). Bit 6 reads the pending interrupt, and writes to bit 6 have no effect. The other bits read 0.
- R5: Any write to location 0 while idle starts work. Without scan enabled, one conversion of the first channel runs, and location 8 bit 7 reads 1 for exactly `CONV_CYCLES` cycles. Location 8 bits 4:0 give the current channel, and bits 6:5 read 1. When the buffer is disabled, locations 0 and 1 return the low and high byte of the last sample, and reading them does not change it.
- R6: A write to location 0 while busy is ignored. The running conversion neither restarts nor lengthens, and it adds no sample.
- R7: When scan is enabled (location 7 bit 2), channels run from the first channel up to the last, wrapping from 31 to 0. Between conversions the block pauses for (4 − code) × `INT_UNIT` cycles. Busy stays set for N×`CONV_CYCLES` + (N−1)×pause in total.
- R8: Location 7 stores buffer enable (bit 3) and scan enable (bit 2). Writing bit 1 empties the FIFO and clears overflow, and bit 1 always reads 0. The status bits are 7 empty, 6 at least half full, 5 full, and 4 overflow. Overflow is sticky once a push meets a full FIFO, and the overflowing sample is dropped. While the buffer is enabled, locations 0 and 1 show the oldest entry, and reading location 1 pops it.
- R9: When a sequence completes with the interrupt enabled, the pending flag and `irq` rise only after the last sample is stored. Writing location 8 with bit 3 set clears them.
- R10: Writing location 8 with bit 5 set returns every register, the sequencer and the FIFO to their reset state in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register location |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read (pops the FIFO at location 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Pending sequence-complete interrupt |

## Verification
The bench builds the block with `CONV_CYCLES`=6, `INT_UNIT`=2 and `FIFO_DEPTH`=8. With those values the busy time of each sequence is short enough to count cycle by cycle, so that pause codes 3 and 0 give busy lengths that differ. A ten-channel scan then overfills the eight-entry FIFO, which makes the full, half-full and overflow flags and the drop of the excess samples visible through the status location.

// File: rtl/adc_scan_pkg.sv
// Shared definitions for the ADC scan controller: bus locations whose
// offsets software decodes, sequencer states and the analog config word.
package adc_scan_pkg;

    localparam int CHAN_W = 5;

    typedef logic [3:0] loc_t;

    localparam loc_t LOC_CONV   = 4'h0;  // start / sample low byte
    localparam loc_t LOC_SMPH   = 4'h1;  // sample high byte
    localparam loc_t LOC_FIRST  = 4'h2;  // first scan channel
    localparam loc_t LOC_LAST   = 4'h3;  // last scan channel
    localparam loc_t LOC_BUFCTL = 4'h7;  // buffer control / status
    localparam loc_t LOC_CTRL   = 4'h8;  // control write / status read
    localparam loc_t LOC_INTC   = 4'h9;  // interrupt and clock select
    localparam loc_t LOC_ACFG   = 4'hB;  // analog configuration

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CONV,
        SQ_GAP
    } seq_state_t;

    typedef struct packed {
        logic [1:0] gap_code;
        logic       range_hi;
        logic       unipolar;
        logic [1:0] gain;
    } acfg_t;

endpackage

// File: rtl/adc_scan_regs.sv
// Register bank of the ADC scan controller.
// Holds the channel bounds, the analog config, the buffer and interrupt
// controls, and the pending interrupt flag. Decodes the start, buffer-clear
// and soft-reset strobes. Assumes one-cycle write strobes.
module adc_scan_regs
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  loc_t              addr,
    input  logic [7:0]        wdata,
    input  logic              seq_done,
    output logic [CHAN_W-1:0] first_ch,
    output logic [CHAN_W-1:0] last_ch,
    output acfg_t             acfg,
    output logic              buf_en,
    output logic              scan_en,
    output logic              adint_en,
    output logic              clk_hw,
    output logic              clk_timer,
    output logic              irq_pend,
    output logic              start,
    output logic              buf_clr,
    output logic              soft_clr
);

    logic ctrl_wr;
    logic pend_clr_wr;
    logic unused_wbit6;

    assign unused_wbit6 = wdata[6];

    // Decode the one-cycle strobes from bus writes.
    always_comb begin
        ctrl_wr     = wr && (addr == LOC_CTRL);
        soft_clr    = ctrl_wr && wdata[5];
        pend_clr_wr = ctrl_wr && wdata[3];
        start       = wr && (addr == LOC_CONV) && !soft_clr;
        buf_clr     = wr && (addr == LOC_BUFCTL) && wdata[1];
    end

    // Configuration storage, cleared by reset or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            first_ch  <= '0;
            last_ch   <= '0;
            acfg      <= '0;
            buf_en    <= 1'b0;
            scan_en   <= 1'b0;
            adint_en  <= 1'b0;
            clk_hw    <= 1'b0;
            clk_timer <= 1'b0;
        end else if (wr) begin
            case (addr)
                LOC_FIRST:  first_ch <= wdata[CHAN_W-1:0];
                LOC_LAST:   last_ch  <= wdata[CHAN_W-1:0];
                LOC_ACFG:   acfg     <= acfg_t'(wdata[5:0]);
                LOC_BUFCTL: begin
                    buf_en  <= wdata[3];
                    scan_en <= wdata[2];
                end
                LOC_INTC: begin
                    adint_en  <= wdata[7];
                    clk_hw    <= wdata[1];
                    clk_timer <= wdata[0];
                end
                default: ;
            endcase
        end
    end

    // Pending interrupt: a new completion wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr)
            irq_pend <= 1'b0;
        else if (seq_done && adint_en)
            irq_pend <= 1'b1;
        else if (pend_clr_wr)
            irq_pend <= 1'b0;
    end

    a_r9_clear_drops_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr_wr && !seq_done) |=> !irq_pend);

    a_r9_done_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && adint_en && !soft_clr) |=> irq_pend);

    a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!irq_pend && !buf_en && !scan_en && first_ch == '0));

endmodule

// File: rtl/adc_scan_seq.sv
// Conversion sequencer with a stubbed converter.
// Each conversion takes CONV_CYCLES cycles. In scan mode the channel steps
// up (modulo 32) after a pause of (4 - code) * INT_UNIT cycles, and the
// sequence stops after the captured last channel. The stub result is
// {STUB_HI, 3'b000, channel}.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int         CONV_CYCLES = 40,
    parameter int         INT_UNIT    = 50,
    parameter logic [7:0] STUB_HI     = 8'hC5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start,
    input  logic              scan_en,
    input  logic [CHAN_W-1:0] first_ch,
    input  logic [CHAN_W-1:0] last_ch,
    input  logic [1:0]        gap_code,
    output logic              busy,
    output logic [CHAN_W-1:0] cur_ch,
    output logic              smp_we,
    output logic [15:0]       smp_data,
    output logic [15:0]       last_smp,
    output logic              done
);

    localparam int MAX_LEN = (CONV_CYCLES > 4 * INT_UNIT) ? CONV_CYCLES : 4 * INT_UNIT;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] CONV_RLD = CNT_W'(CONV_CYCLES - 1);

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  gap_rld;
    logic              scan_q;
    logic [CHAN_W-1:0] stop_ch;
    logic              conv_end;
    logic              is_last;

    // Reload value for the pause between channels, from the 2-bit code.
    always_comb begin
        case (gap_code)
            2'd0:    gap_rld = CNT_W'(4 * INT_UNIT - 1);
            2'd1:    gap_rld = CNT_W'(3 * INT_UNIT - 1);
            2'd2:    gap_rld = CNT_W'(2 * INT_UNIT - 1);
            default: gap_rld = CNT_W'(INT_UNIT - 1);
        endcase
    end

    // Conversion completion, last-channel test and stub result.
    always_comb begin
        conv_end = (state == SQ_CONV) && (cnt == '0);
        is_last  = !scan_q || (cur_ch == stop_ch);
        smp_we   = conv_end;
        done     = conv_end && is_last;
        busy     = (state != SQ_IDLE);
        smp_data = {STUB_HI, 3'b000, cur_ch};
    end

    // Sequencer state, cycle counter and channel stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            cur_ch   <= '0;
            scan_q   <= 1'b0;
            stop_ch  <= '0;
            last_smp <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    state   <= SQ_CONV;
                    cnt     <= CONV_RLD;
                    cur_ch  <= first_ch;
                    scan_q  <= scan_en;
                    stop_ch <= last_ch;
                end
                SQ_CONV: if (cnt == '0) begin
                    last_smp <= smp_data;
                    if (is_last) begin
                        state <= SQ_IDLE;
                    end else begin
                        state  <= SQ_GAP;
                        cnt    <= gap_rld;
                        cur_ch <= cur_ch + 1'b1;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
                SQ_GAP: if (cnt == '0) begin
                    state <= SQ_CONV;
                    cnt   <= CONV_RLD;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    a_r5_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == SQ_IDLE && start) |=> (busy && cur_ch == $past(first_ch)));

    a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == SQ_CONV && cnt != '0 && start) |=> (state == SQ_CONV && $stable(cur_ch)));

    a_r7_channel_step: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (conv_end && !is_last) |=> (cur_ch == $past(cur_ch) + 5'd1));

    a_r9_done_with_sample: assert property (@(posedge clk) disable iff (!rst_n || clr)
        done |=> (!busy && last_smp[CHAN_W-1:0] == $past(cur_ch)));

endmodule

// File: rtl/adc_scan_fifo.sv
// Sample FIFO of FIFO_DEPTH 16-bit entries (a power of two, at least 2).
// A push into a full FIFO is dropped and sets a sticky overflow flag.
// clr empties the FIFO and clears overflow.
module adc_scan_fifo #(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        push,
    input  logic [15:0] din,
    input  logic        pop,
    output logic [15:0] dout,
    output logic        empty,
    output logic        half,
    output logic        full,
    output logic        ovf
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);
    localparam logic [AW:0] HALF_CNT = (AW + 1)'(DEPTH / 2);

    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [AW:0]   count;
    logic          do_push;
    logic          do_pop;
    logic [15:0]   ent [DEPTH];

    // Accepted push / pop and the level flags.
    always_comb begin
        empty   = (count == '0);
        full    = (count == FULL_CNT);
        half    = (count >= HALF_CNT);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = ent[rptr];
    end

    // One storage register per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [15:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (do_push && wptr == AW'(g))
                q <= din;
        end
        assign ent[g] = q;
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end

    a_r8_overflow_on_full: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (push && full && !pop) |=> (ovf && full));

    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n || clr)
        ovf |=> ovf);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

endmodule

// File: rtl/adc_scan_ctl.sv
// Top of the ADC scan controller.
// Connects the register bank, the sequencer and the sample FIFO, and drives
// the combinational read mux. Reads have no side effect except a strobed
// read of location 1, which pops the FIFO while the buffer is enabled.
module adc_scan_ctl
    import adc_scan_pkg::*;
#(
    parameter int         CONV_CYCLES = 40,
    parameter int         INT_UNIT    = 50,
    parameter int         FIFO_DEPTH  = 16,
    parameter logic [7:0] STUB_HI     = 8'hC5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);

    logic [CHAN_W-1:0] first_ch;
    logic [CHAN_W-1:0] last_ch;
    logic [CHAN_W-1:0] cur_ch;
    acfg_t             acfg;
    logic              buf_en;
    logic              scan_en;
    logic              adint_en;
    logic              clk_hw;
    logic              clk_timer;
    logic              irq_pend;
    logic              start;
    logic              buf_clr;
    logic              soft_clr;
    logic              busy;
    logic              smp_we;
    logic              seq_done;
    logic [15:0]       smp_data;
    logic [15:0]       last_smp;
    logic [15:0]       fifo_dout;
    logic [15:0]       smp_view;
    logic              f_empty;
    logic              f_half;
    logic              f_full;
    logic              f_ovf;
    logic              pop;

    adc_scan_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .seq_done  (seq_done),
        .first_ch  (first_ch),
        .last_ch   (last_ch),
        .acfg      (acfg),
        .buf_en    (buf_en),
        .scan_en   (scan_en),
        .adint_en  (adint_en),
        .clk_hw    (clk_hw),
        .clk_timer (clk_timer),
        .irq_pend  (irq_pend),
        .start     (start),
        .buf_clr   (buf_clr),
        .soft_clr  (soft_clr)
    );

    adc_scan_seq #(
        .CONV_CYCLES (CONV_CYCLES),
        .INT_UNIT    (INT_UNIT),
        .STUB_HI     (STUB_HI)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_clr),
        .start    (start),
        .scan_en  (scan_en),
        .first_ch (first_ch),
        .last_ch  (last_ch),
        .gap_code (acfg.gap_code),
        .busy     (busy),
        .cur_ch   (cur_ch),
        .smp_we   (smp_we),
        .smp_data (smp_data),
        .last_smp (last_smp),
        .done     (seq_done)
    );

    adc_scan_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr || soft_clr),
        .push  (smp_we && buf_en),
        .din   (smp_data),
        .pop   (pop),
        .dout  (fifo_dout),
        .empty (f_empty),
        .half  (f_half),
        .full  (f_full),
        .ovf   (f_ovf)
    );

    // Pop on a strobed high-byte read while the buffer is enabled.
    always_comb begin
        pop      = bus_rd && (bus_addr == LOC_SMPH) && buf_en && !f_empty;
        smp_view = buf_en ? fifo_dout : last_smp;
        irq      = irq_pend;
    end

    // Read mux over the bus locations.
    always_comb begin
        case (bus_addr)
            LOC_CONV:   bus_rdata = smp_view[7:0];
            LOC_SMPH:   bus_rdata = smp_view[15:8];
            LOC_FIRST:  bus_rdata = {3'b000, first_ch};
            LOC_LAST:   bus_rdata = {3'b000, last_ch};
            LOC_BUFCTL: bus_rdata = {f_empty, f_half, f_full, f_ovf, buf_en, scan_en, 2'b00};
            LOC_CTRL:   bus_rdata = {busy, 2'b11, cur_ch};
            LOC_INTC:   bus_rdata = {adint_en, irq_pend, 4'b0000, clk_hw, clk_timer};
            LOC_ACFG:   bus_rdata = {busy, 1'b0, acfg};
            default:    bus_rdata = 8'h00;
        endcase
    end

    a_r8_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !smp_we && !buf_clr && !soft_clr && $countones({f_empty, f_full}) == 0)
        |=> !f_full);

endmodule

// File: tb/sim_adc_scan_ctl.sv
module sim_adc_scan_ctl;

    localparam int CONV = 6;
    localparam int UNIT = 2;
    localparam int DEP  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_scan_ctl #(
        .CONV_CYCLES (CONV),
        .INT_UNIT    (UNIT),
        .FIFO_DEPTH  (DEP),
        .STUB_HI     (8'hC5)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Table entries: {requirement number, location, write data, expected readback}.
    localparam int NT = 11;
    localparam logic [23:0] TBL [NT] = '{
        {4'd2, 4'h2, 8'h80, 8'h00},   // R2
        {4'd2, 4'h3, 8'hFF, 8'h1F},   // R2
        {4'd2, 4'h2, 8'h3D, 8'h1D},   // R2
        {4'd2, 4'h3, 8'h21, 8'h01},   // R2
        {4'd3, 4'hB, 8'hFF, 8'h3F},   // R3
        {4'd3, 4'hB, 8'h2A, 8'h2A},   // R3
        {4'd4, 4'h9, 8'hFF, 8'h83},   // R4
        {4'd4, 4'h9, 8'h00, 8'h00},   // R4
        {4'd8, 4'h7, 8'h0C, 8'h8C},   // R8
        {4'd8, 4'h7, 8'h04, 8'h84},   // R8
        {4'd8, 4'h7, 8'h00, 8'h80}    // R8
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Count the cycles busy stays set, starting just after a start write.
    task automatic busy_len(output int n);
        n = 0;
        bus_addr = 4'h8;
        #1;
        while (bus_rdata[7] && n < 2000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset readbacks and probe signature
        chk_rd("R1", 4'h8, 8'h60);
        chk_rd("R1", 4'h7, 8'h80);
        chk_rd("R1", 4'h9, 8'h00);
        chk("R1", int'(irq), 0);
        wr(4'h2, 8'h80);
        wr(4'h3, 8'hFF);
        wr(4'hB, 8'h0C);
        chk_rd("R1", 4'h2, 8'h00);
        chk_rd("R1", 4'h3, 8'h1F);
        chk_rd("R1", 4'h7, 8'h80);
        chk_rd("R1", 4'h8, 8'h60);
        chk_rd("R1", 4'h9, 8'h00);
        chk_rd("R1", 4'hB, 8'h0C);

        // Register write/readback table (R2, R3, R4, R8)
        for (int i = 0; i < NT; i++) begin
            logic [7:0] v;
            wr(TBL[i][19:16], TBL[i][15:8]);
            rd(TBL[i][19:16], v);
            chk($sformatf("R%0d table row %0d", TBL[i][23:20], i), v, TBL[i][7:0]);
        end

        // R5: single conversion of the first channel, buffer off
        wr(4'hB, 8'h00);
        wr(4'h2, 8'h05);
        wr(4'h3, 8'h09);
        wr(4'h0, 8'hFF);
        busy_len(n);
        chk("R5 busy length", n, CONV);
        chk_rd("R5", 4'h0, 8'h05);
        chk_rd("R5", 4'h1, 8'hC5);
        chk_rd("R5 reread", 4'h1, 8'hC5);
        chk_rd("R5 status", 4'h8, 8'h65);
        chk("R5 no irq when disabled", int'(irq), 0);

        // R6: second start during conversion ignored
        wr(4'h7, 8'h08);
        wr(4'h0, 8'hFF);
        wr(4'h0, 8'hFF);
        busy_len(n);
        chk("R6 busy not extended", n, CONV - 2);
        chk_rd("R6 one entry", 4'h7, 8'h08);
        chk_rd("R6", 4'h0, 8'h05);
        chk_rd("R6", 4'h1, 8'hC5);
        chk_rd("R6 buffer empty", 4'h7, 8'h88);

        // R7 / R9: wrapping scan 30..1 with pause code 3 and interrupt on
        wr(4'h7, 8'h02);
        wr(4'h7, 8'h0C);
        wr(4'hB, 8'h30);
        wr(4'h2, 8'h1E);
        wr(4'h3, 8'h01);
        wr(4'h9, 8'h80);
        wr(4'h0, 8'h00);
        busy_len(n);
        chk("R7 busy code 3", n, 4 * CONV + 3 * UNIT);
        chk("R9 irq after scan", int'(irq), 1);
        chk_rd("R9 pending bit", 4'h9, 8'hC0);
        chk_rd("R7 last channel", 4'h8, 8'h61);
        chk_rd("R8 half", 4'h7, 8'h4C);
        begin
            logic [7:0] exp_ch [4] = '{8'h1E, 8'h1F, 8'h00, 8'h01};
            for (int k = 0; k < 4; k++) begin
                chk_rd("R7 channel order", 4'h0, exp_ch[k]);
                chk_rd("R7 high byte", 4'h1, 8'hC5);
            end
        end
        chk_rd("R8 drained", 4'h7, 8'h8C);
        wr(4'h8, 8'h08);
        chk("R9 cleared", int'(irq), 0);
        chk_rd("R9 pending bit cleared", 4'h9, 8'h80);

        // R7: pause code 0 on channels 3..5
        wr(4'hB, 8'h00);
        wr(4'h2, 8'h03);
        wr(4'h3, 8'h05);
        wr(4'h0, 8'h00);
        busy_len(n);
        chk("R7 busy code 0", n, 3 * CONV + 2 * 4 * UNIT);
        chk("R9 irq again", int'(irq), 1);

        // R8: overflow with ten samples into eight entries
        wr(4'h7, 8'h0E);
        chk_rd("R8 reset self-clears", 4'h7, 8'h8C);
        wr(4'hB, 8'h30);
        wr(4'h2, 8'h00);
        wr(4'h3, 8'h09);
        wr(4'h0, 8'h00);
        busy_len(n);
        chk("R7 ten-channel busy", n, 10 * CONV + 9 * UNIT);
        chk_rd("R8 full overflow", 4'h7, 8'h7C);
        chk_rd("R8 oldest kept", 4'h0, 8'h00);
        wr(4'h7, 8'h0E);
        chk_rd("R8 overflow cleared", 4'h7, 8'h8C);

        // R10: soft reset restores reset state
        wr(4'h2, 8'h07);
        wr(4'hB, 8'h2A);
        wr(4'h9, 8'h83);
        chk("R10 irq before", int'(irq), 1);
        wr(4'h8, 8'h20);
        chk("R10 irq", int'(irq), 0);
        chk_rd("R10", 4'h2, 8'h00);
        chk_rd("R10", 4'hB, 8'h00);
        chk_rd("R10", 4'h9, 8'h00);
        chk_rd("R10", 4'h7, 8'h80);
        chk_rd("R10", 4'h8, 8'h60);
        chk_rd("R10", 4'h0, 8'h00);

        summary();
    end

endmodule